// File: doc/BRIEF.md
# Timer Tick Prescaler

This block turns a fast system clock into a count-enable strobe for timer channels. It does not produce derived clocks. The base clock is nominally an 18 MHz oscillator. A six-bit divide field sits inside a shared 32-bit configuration word, and the block decodes it into a division ratio:

- an even value from 2 to 62 divides by that value;
- zero divides by two;
- any odd value bypasses division, so a strobe appears on every cycle.

The same configuration word carries one clock-enable bit per timer channel. When a channel is unused, clearing its bit holds that channel's strobe low to save power. The two bits are independent.

Software updates the word through a write port that has a per-bit write mask. Bits that are not selected by the mask keep their stored values, which matches a read-modify-write of the shared register. Any write that touches the divide field restarts the internal divider. The first strobe after a ratio change therefore arrives one full new period later.

All channels share a single divider counter. Each channel's output is the shared strobe gated by that channel's enable bit.

Top module: `tmr_prescaler`

## Requirements
- R1: While reset is asserted and after it is released, the configuration word reads 0 (divide field 0, both channels disabled), and every tick output is low.
- R2: The divide field occupies bits 21:16 of the configuration word. For an even value N with 2 <= N <= 62, an enabled channel ticks for exactly one cycle out of every N.
- R3: For any odd divide field value, 1 included, an enabled channel ticks on every cycle.
- R4: A divide field value of 0 makes an enabled channel tick once every 2 cycles.
- R5: Channel i's clock-enable bit is bit i of the configuration word (bits 0 and 1). While that bit is 0, tick[i] stays low. Each bit affects only its own channel.
- R6: A write changes only the bits whose write-mask bit is 1. The stored word appears on cfg_rdata from the cycle after the write.
- R7: A write whose mask covers any of bits 21:16 restarts the divider. With the new ratio R, the first tick is high during the R-th cycle after the write edge.
- R8: A write whose mask covers none of bits 21:16 leaves the divider phase untouched, so the tick spacing continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominal 18 MHz base) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_wmask | input | 32 | Per-bit write mask; 1 selects the bit for update |
| cfg_rdata | output | 32 | Stored configuration word |
| tick | output | 2 | Per-channel count-enable strobe |

## Verification
The bench builds the block with its default parameters: a six-bit divide field at bit 16, two channels, and enable bits at positions 0 and 1. With these values every one of the 64 field codes can be swept. This covers the largest ratio of 62, the zero code, and every odd bypass code, and the sweep runs against a behavioural phase counter. Masked writes land both inside and outside the divide field at arbitrary phases, which exposes restart-versus-continue errors. The two enable bits are toggled separately, which exposes any crossing between channels.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;

    typedef enum logic [1:0] {
        DIV_BYPASS,
        DIV_BY_TWO,
        DIV_BY_FIELD
    } div_kind_e;

    // Classify a raw divide field value
    function automatic div_kind_e div_kind(input int unsigned f);
        if (f[0])
            return DIV_BYPASS;
        else if (f == 0)
            return DIV_BY_TWO;
        else
            return DIV_BY_FIELD;
    endfunction

    // Terminal count (ratio minus one) for a field value
    function automatic int unsigned div_last(input int unsigned f);
        case (div_kind(f))
            DIV_BYPASS: return 0;
            DIV_BY_TWO: return 1;
            default:    return f - 1;
        endcase
    endfunction

endpackage

// File: rtl/tmr_presc_cfg.sv
module tmr_presc_cfg #(
    parameter int DATA_W    = 32,
    parameter int DIV_LSB   = 16,
    parameter int DIV_W     = 6,
    parameter int NCH       = 2,
    parameter int EN_LSB    = 0,
    parameter logic [DATA_W-1:0] RESET_CFG = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DIV_W-1:0]  div_field,
    output logic [NCH-1:0]    ch_en,
    output logic              div_restart
);
    localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= RESET_CFG;
        else if (wr)
            cfg_q <= (cfg_q & ~wmask) | (wdata & wmask);
    end

    assign div_field   = cfg_q[DIV_MSB:DIV_LSB];
    assign div_restart = wr && (|wmask[DIV_MSB:DIV_LSB]);

    for (genvar i = 0; i < NCH; i++) begin : g_en
        assign ch_en[i] = cfg_q[EN_LSB + i];
    end

    // R6
    keep_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((cfg_q ^ $past(cfg_q)) & ~$past(wmask)) == '0);

    // R6
    hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg_q));

endmodule

// File: rtl/tmr_presc_div.sv
module tmr_presc_div
    import tmr_presc_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_field,
    input  logic             restart,
    output logic             base_tick
);
    localparam int CNT_W = DIV_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = CNT_W'(div_last(int'(unsigned'(div_field))));
    end

    assign base_tick = (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart || base_tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt_q == '0);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_cnt);

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (base_tick && !restart && last_cnt != '0) |=> !base_tick);

endmodule

// File: rtl/tmr_presc_gate.sv
module tmr_presc_gate #(
    parameter int NCH = 2
) (
    input  logic           base_tick,
    input  logic [NCH-1:0] ch_en,
    output logic [NCH-1:0] tick
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign tick[i] = base_tick & ch_en[i];
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DATA_W  = 32,
    parameter int DIV_LSB = 16,
    parameter int DIV_W   = 6,
    parameter int NCH     = 2,
    parameter int EN_LSB  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [DATA_W-1:0] cfg_wmask,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [NCH-1:0]    tick
);
    logic [DIV_W-1:0] div_field;
    logic [NCH-1:0]   ch_en;
    logic             div_restart;
    logic             base_tick;

    tmr_presc_cfg #(
        .DATA_W (DATA_W),
        .DIV_LSB(DIV_LSB),
        .DIV_W  (DIV_W),
        .NCH    (NCH),
        .EN_LSB (EN_LSB)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr         (cfg_wr),
        .wdata      (cfg_wdata),
        .wmask      (cfg_wmask),
        .cfg_q      (cfg_rdata),
        .div_field  (div_field),
        .ch_en      (ch_en),
        .div_restart(div_restart)
    );

    tmr_presc_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .div_field(div_field),
        .restart  (div_restart),
        .base_tick(base_tick)
    );

    tmr_presc_gate #(.NCH(NCH)) u_gate (
        .base_tick(base_tick),
        .ch_en    (ch_en),
        .tick     (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5
        gated_low_chk: assert property (@(posedge clk) disable iff (rst)
            !ch_en[i] |-> !tick[i]);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (tick == '0 && cfg_rdata == '0));

endmodule

// File: tb/sim_tmr_prescaler.sv
`timescale 1ns/1ps
module sim_tmr_prescaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_wmask = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  tick;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // reference model state
    logic [31:0] m_cfg = '0;
    int          m_cnt = 0;
    bit          m_restarted = 1'b0;
    bit          m_sidewrite = 1'b0;

    always #2 clk = ~clk;

    tmr_prescaler u0 (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .cfg_wmask(cfg_wmask),
        .cfg_rdata(cfg_rdata),
        .tick     (tick)
    );

    function automatic int ratio_of(input logic [5:0] f);
        if (f % 2 == 1) return 1;
        if (f == 0)     return 2;
        return int'(f);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic string tag_for(input int ch);
        logic [5:0] f = m_cfg[21:16];
        if (!m_cfg[ch])      return "R5";
        if (m_restarted)     return "R7";
        if (m_sidewrite)     return "R8";
        if (f % 2 == 1)      return "R3";
        if (f == 0)          return "R4";
        return "R2";
    endfunction

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(input bit wr, input logic [31:0] d, input logic [31:0] m);
        int r;
        bit exp_t;
        cfg_wr = wr; cfg_wdata = d; cfg_wmask = m;
        @(posedge clk);
        r = ratio_of(m_cfg[21:16]);
        if (wr && (m[21:16] != 0)) begin
            m_cnt = 0;
            m_restarted = 1'b1;
        end else begin
            if (m_cnt == r - 1) begin
                m_cnt = 0;
                m_restarted = 1'b0;
                m_sidewrite = 1'b0;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr) m_sidewrite = 1'b1;
        end
        if (wr) m_cfg = (m_cfg & ~m) | (d & m);
        @(negedge clk);
        cycles++;
        r = ratio_of(m_cfg[21:16]);
        for (int c = 0; c < 2; c++) begin
            exp_t = m_cfg[c] && (m_cnt == r - 1);
            chk(tag_for(c), 32'(tick[c]), 32'(exp_t));
        end
        chk("R6", cfg_rdata, m_cfg);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, '0, '0);
    endtask

    task automatic set_div(input logic [5:0] f);
        step(1'b1, {10'd0, f, 16'd0}, 32'h003F_0000);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", cfg_rdata, 32'h0);
        chk("R1", 32'(tick), 32'h0);
        rst = 1'b0;
        idle(4);
        chk("R1", cfg_rdata, 32'h0);

        // enable both channels, default field 0 -> divide by 2 (R4)
        step(1'b1, 32'h0000_0003, 32'h0000_0003);
        idle(8);

        // sweep every field value (R2, R3, R4, R7)
        for (int f = 0; f < 64; f++) begin
            set_div(6'(f));
            idle(2 * ratio_of(6'(f)) + 2);
        end

        // R8: writes outside the divide field mid-period
        set_div(6'd10);
        idle(3);
        step(1'b1, 32'hA5A0_0000, 32'hFFC0_0000);
        idle(4);
        step(1'b1, 32'h0000_F00C, 32'h0000_FFFC);
        idle(15);

        // R5: channel enables independent
        step(1'b1, 32'h0000_0000, 32'h0000_0001);
        idle(12);
        step(1'b1, 32'h0000_0001, 32'h0000_0003);
        idle(12);
        step(1'b1, 32'h0000_0000, 32'h0000_0003);
        idle(12);

        // R7: rewrite same value restarts phase; R6 partial mask into the field
        step(1'b1, 32'h0000_0003, 32'h0000_0003);
        set_div(6'd6);
        idle(3);
        set_div(6'd6);
        idle(10);
        step(1'b1, 32'h0004_0000, 32'h0004_0000);
        idle(10);
        step(1'b1, 32'h003F_0000, 32'h0001_0000);
        idle(6);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int w = 0; w < 100000; w++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule